// File: doc/BRIEF.md
# EEPROM Program/Erase Sequencer

This block sits behind a CPU bus and models how a small on-chip EEPROM is changed. The array is a synchronous byte RAM inside the block. Its top byte doubles as a configuration byte, and that byte can be reached through a separate alias select. A control register governs a two-step handshake. Software first opens the latch, then writes one array byte, which captures an address/data pair and leaves the array untouched. It then raises the programming voltage, waits, and drops it again. On that falling step the block either clears bits in the target byte or erases a single byte, a 16-byte row or the whole array to all-ones.

Each rule violation raises a sticky error flag and records a 3-bit cause. The flag clears on reset or on an explicit clear strobe. While the halted input is high, array writes bypass the handshake and store directly, as a debugger would. Row and bulk erase walk the array one byte per cycle with `busy` high. Reads are combinational at any time.

Top module: `eeprom_seq`

## Requirements
- R1: An access with `wr_wide` high is rejected: it sets error cause 1 and changes neither the array nor the control register.
- R2: The control register fields are bit0 latch-enable, bit1 program-voltage, bit2 erase-select, bit3 byte-erase and bit4 row-erase, and it reads back on `ctrl_out`. Every write presented while `busy` is high is ignored.
- R3: A control write that raises latch-enable and program-voltage together from both clear is discarded and sets cause 2.
- R4: A control write with latch-enable clear stores zero in every control field.
- R5: Raising program-voltage while no address/data pair is held sets cause 3. The write still takes effect. Dropping both bits together is legal and raises no error.
- R6: With halted low, an array write while latch-enable is clear sets cause 5. With a pair already held, it sets cause 6. Otherwise it captures the pair. None of these three cases changes the array.
- R7: With halted high, an array write stores its data directly in the addressed byte.
- R8: Dropping program-voltage while a pair is held and erase-select is clear sets the target byte to old AND latched data, then releases the pair.
- R9: The voltage-high time is counted in clock cycles from the raising write to the dropping write. A count below MIN_DWELL sets cause 4, but the operation still completes. A count equal to MIN_DWELL is accepted.
- R10: A completion with erase-select and byte-erase set, or any erase whose target is the top byte, writes 0xFF to the target byte only.
- R11: A row erase fills the 16-byte row whose base has the low four address bits cleared, one byte per cycle with `busy` high. The top byte is skipped.
- R12: A bulk erase fills every byte except the top byte with 0xFF, one per cycle with `busy` high.
- R13: An access with select code 2 (config alias) targets the top array byte whatever `wr_addr` holds. Code 0 targets `wr_addr`, code 1 the control register, and code 3 does nothing.
- R14: `err_flag` stays high until reset or `err_clr`. `err_code` holds the latest cause and reads 0 when the flag is low. An error in the same cycle as `err_clr` wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Write strobe, one cycle per access |
| wr_sel | input | 2 | 0 array, 1 control, 2 config alias, 3 none |
| wr_wide | input | 1 | Access is wider than one byte |
| wr_addr | input | AW | Array byte address |
| wr_data | input | 8 | Write data |
| halted | input | 1 | CPU halted: array writes go straight in |
| err_clr | input | 1 | Clears the sticky error |
| rd_addr | input | AW | Read address |
| rd_data | output | 8 | Combinational array read |
| ctrl_out | output | 5 | Control register contents |
| busy | output | 1 | Row or bulk erase in progress |
| err_flag | output | 1 | Sticky error flag |
| err_code | output | 3 | Latest error cause |

## Verification
Two pairs of actions can land on the same edge. The first pair is a new error event and the clear strobe. The bench drives a wide access together with `err_clr` and expects the flag to stay set with cause 1. The second pair is a multi-cycle erase sweep and an incoming bus write. The bench issues a control write while a bulk erase is running, then checks that the control register is unchanged and that the sweep still runs its full length, counting the cycles `busy` stays high.

// File: rtl/eeprom_seq_pkg.sv
package eeprom_seq_pkg;

  typedef struct packed {
    logic row_er;
    logic byte_er;
    logic erase;
    logic vpp;
    logic latch;
  } ctl_t;

  localparam logic [1:0] SEL_ARRAY = 2'd0;
  localparam logic [1:0] SEL_CTRL  = 2'd1;
  localparam logic [1:0] SEL_CFG   = 2'd2;

  localparam logic [2:0] ERR_NONE    = 3'd0;
  localparam logic [2:0] ERR_WIDE    = 3'd1;
  localparam logic [2:0] ERR_BOTH    = 3'd2;
  localparam logic [2:0] ERR_NO_PAIR = 3'd3;
  localparam logic [2:0] ERR_SHORT   = 3'd4;
  localparam logic [2:0] ERR_LOCKED  = 3'd5;
  localparam logic [2:0] ERR_HELD    = 3'd6;

  localparam int ROW_SHIFT = 4;

  // Programming can only clear bits.
  function automatic logic [7:0] prog_merge(input logic [7:0] old_b, input logic [7:0] dat);
    return old_b & dat;
  endfunction

  function automatic logic [15:0] row_first(input logic [15:0] a);
    return a & ~16'((1 << ROW_SHIFT) - 1);
  endfunction

  // Last byte of the row, clipped so the protected top byte is never reached.
  function automatic logic [15:0] row_last(input logic [15:0] a, input logic [15:0] cap);
    logic [15:0] e;
    e = row_first(a) + 16'((1 << ROW_SHIFT) - 1);
    return (e > cap) ? cap : e;
  endfunction

  function automatic logic dwell_short(input logic [31:0] elapsed, input logic [31:0] min_c);
    return elapsed < min_c;
  endfunction

endpackage

// File: rtl/eeprom_seq_dwell.sv
module eeprom_seq_dwell #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  output logic [CW-1:0] elapsed
);
  logic [CW-1:0] cyc;
  logic [CW-1:0] stamp;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cyc   <= '0;
      stamp <= '0;
    end else begin
      cyc <= cyc + 1'b1;
      if (start) stamp <= cyc;
    end
  end

  assign elapsed = cyc - stamp;
endmodule

// File: rtl/eeprom_seq_sweep.sv
module eeprom_seq_sweep #(
  parameter int AW = 9
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          go,
  input  logic [AW-1:0] first,
  input  logic [AW-1:0] last,
  output logic          busy,
  output logic          we,
  output logic [AW-1:0] ptr
);
  logic          active;
  logic [AW-1:0] stop;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
      ptr    <= '0;
      stop   <= '0;
    end else if (go) begin
      active <= 1'b1;
      ptr    <= first;
      stop   <= last;
    end else if (active) begin
      if (ptr == stop) active <= 1'b0;
      else             ptr    <= ptr + 1'b1;
    end
  end

  assign busy = active;
  assign we   = active;
endmodule

// File: rtl/eeprom_seq_ctrl.sv
module eeprom_seq_ctrl
  import eeprom_seq_pkg::*;
#(
  parameter int AW    = 9,
  parameter int DEPTH = 512
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          acc_en,
  input  logic [1:0]    acc_sel,
  input  logic          acc_wide,
  input  logic [AW-1:0] acc_addr,
  input  logic [7:0]    acc_data,
  input  logic          halted,
  input  logic          dwell_short_i,
  output ctl_t          ctl_q,
  output logic          pair_valid,
  output logic [AW-1:0] pair_addr,
  output logic [7:0]    pair_data,
  output logic          ev_rise,
  output logic          ev_done,
  output ctl_t          done_op,
  output logic          ev_direct,
  output logic [AW-1:0] direct_addr,
  output logic [7:0]    direct_data,
  output logic          ev_err,
  output logic [2:0]    ev_code
);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic    is_ctl, is_arr, both_up, capture;
  ctl_t    nw, nz;
  logic [AW-1:0] tgt;

  always_comb begin
    is_ctl  = acc_en && !acc_wide && (acc_sel == SEL_CTRL);
    is_arr  = acc_en && !acc_wide && ((acc_sel == SEL_ARRAY) || (acc_sel == SEL_CFG));
    tgt     = (acc_sel == SEL_CFG) ? LAST : acc_addr;
    nw      = ctl_t'(acc_data[4:0]);
    both_up = !ctl_q.latch && !ctl_q.vpp && nw.latch && nw.vpp;
    nz      = nw.latch ? nw : '0;
    ev_rise = is_ctl && !both_up && nz.vpp && !ctl_q.vpp;
    ev_done = is_ctl && !both_up && ctl_q.vpp && !nz.vpp && pair_valid;
    done_op = ctl_q;
    ev_direct   = is_arr && halted;
    direct_addr = tgt;
    direct_data = acc_data;
    capture = is_arr && !halted && ctl_q.latch && !pair_valid;

    ev_err  = 1'b1;
    if (acc_en && acc_wide)                        ev_code = ERR_WIDE;
    else if (is_ctl && both_up)                    ev_code = ERR_BOTH;
    else if (ev_rise && !pair_valid)               ev_code = ERR_NO_PAIR;
    else if (ev_done && dwell_short_i)             ev_code = ERR_SHORT;
    else if (is_arr && !halted && !ctl_q.latch)    ev_code = ERR_LOCKED;
    else if (is_arr && !halted && pair_valid)      ev_code = ERR_HELD;
    else begin
      ev_err  = 1'b0;
      ev_code = ERR_NONE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q      <= '0;
      pair_valid <= 1'b0;
      pair_addr  <= '0;
      pair_data  <= '0;
    end else begin
      if (is_ctl && !both_up) ctl_q <= nz;
      if (capture) begin
        pair_valid <= 1'b1;
        pair_addr  <= tgt;
        pair_data  <= acc_data;
      end else if (ev_done) begin
        pair_valid <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/eeprom_seq.sv
module eeprom_seq
  import eeprom_seq_pkg::*;
#(
  parameter int DEPTH     = 512,
  parameter int AW        = $clog2(DEPTH),
  parameter int MIN_DWELL = 8,
  parameter int CW        = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [1:0]    wr_sel,
  input  logic          wr_wide,
  input  logic [AW-1:0] wr_addr,
  input  logic [7:0]    wr_data,
  input  logic          halted,
  input  logic          err_clr,
  input  logic [AW-1:0] rd_addr,
  output logic [7:0]    rd_data,
  output logic [4:0]    ctrl_out,
  output logic          busy,
  output logic          err_flag,
  output logic [2:0]    err_code
);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic [7:0] mem [DEPTH];

  ctl_t          ctl_q, done_op;
  logic          pair_valid, ev_rise, ev_done, ev_direct, ev_err, short_dwell;
  logic [AW-1:0] pair_addr, direct_addr, sw_first, sw_last, sw_ptr;
  logic [7:0]    pair_data, direct_data;
  logic [2:0]    ev_code;
  logic [CW-1:0] elapsed;
  logic          sw_go, sw_we, sw_busy, acc_en;
  logic          tgt_top, do_prog, do_byte;

  assign acc_en      = wr_en && !sw_busy;
  assign short_dwell = dwell_short(32'(elapsed), 32'(MIN_DWELL));

  eeprom_seq_ctrl #(.AW(AW), .DEPTH(DEPTH)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .acc_en(acc_en), .acc_sel(wr_sel),
    .acc_wide(wr_wide), .acc_addr(wr_addr), .acc_data(wr_data),
    .halted(halted), .dwell_short_i(short_dwell), .ctl_q(ctl_q),
    .pair_valid(pair_valid), .pair_addr(pair_addr), .pair_data(pair_data),
    .ev_rise(ev_rise), .ev_done(ev_done), .done_op(done_op),
    .ev_direct(ev_direct), .direct_addr(direct_addr), .direct_data(direct_data),
    .ev_err(ev_err), .ev_code(ev_code)
  );

  eeprom_seq_dwell #(.CW(CW)) u_dwell (
    .clk(clk), .rst_n(rst_n), .start(ev_rise), .elapsed(elapsed)
  );

  // Completion decode: program, single-byte erase, or a sweep launch.
  always_comb begin
    tgt_top  = (pair_addr == LAST);
    do_prog  = ev_done && !done_op.erase;
    do_byte  = ev_done && done_op.erase && (done_op.byte_er || tgt_top);
    sw_go    = ev_done && done_op.erase && !done_op.byte_er && !tgt_top;
    sw_first = done_op.row_er ? AW'(row_first(16'(pair_addr))) : '0;
    sw_last  = done_op.row_er ? AW'(row_last(16'(pair_addr), 16'(LAST) - 16'd1))
                              : LAST - 1'b1;
  end

  eeprom_seq_sweep #(.AW(AW)) u_sweep (
    .clk(clk), .rst_n(rst_n), .go(sw_go), .first(sw_first), .last(sw_last),
    .busy(sw_busy), .we(sw_we), .ptr(sw_ptr)
  );

  always_ff @(posedge clk) begin
    if (sw_we)          mem[sw_ptr]      <= 8'hFF;
    else if (ev_direct) mem[direct_addr] <= direct_data;
    else if (do_prog)   mem[pair_addr]   <= prog_merge(mem[pair_addr], pair_data);
    else if (do_byte)   mem[pair_addr]   <= 8'hFF;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_flag <= 1'b0;
      err_code <= ERR_NONE;
    end else if (ev_err) begin
      err_flag <= 1'b1;
      err_code <= ev_code;
    end else if (err_clr) begin
      err_flag <= 1'b0;
      err_code <= ERR_NONE;
    end
  end

  assign rd_data  = mem[rd_addr];
  assign ctrl_out = ctl_q;
  assign busy     = sw_busy;
endmodule

// File: rtl/eeprom_seq_chk.sv
module eeprom_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       wr_en,
  input logic [1:0] wr_sel,
  input logic       wr_wide,
  input logic [7:0] wr_data,
  input logic       err_clr,
  input logic [4:0] ctrl_out,
  input logic       busy,
  input logic       err_flag,
  input logic [2:0] err_code,
  input logic       sw_go
);
  a_r1_wide_flags: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && wr_wide && !busy |=> err_flag && err_code == 3'd1);

  a_r2_ctrl_frozen_busy: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(ctrl_out));

  a_r3_both_rejected: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && !busy && !wr_wide && wr_sel == 2'd1 && wr_data[1:0] == 2'b11 &&
    ctrl_out[1:0] == 2'b00 |=> ctrl_out == 5'd0 && err_code == 3'd2);

  a_r4_latch_gates: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_out[0] |-> ctrl_out == 5'd0);

  a_r5_vpp_under_latch: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_out[1] |-> ctrl_out[0]);

  a_r11_sweep_busy: assert property (@(posedge clk) disable iff (!rst_n)
    sw_go |=> busy);

  a_r14_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    err_flag && !err_clr |=> err_flag);

  a_r14_code_pairing: assert property (@(posedge clk) disable iff (!rst_n)
    (err_flag ? (err_code != 3'd0 && err_code <= 3'd6) : (err_code == 3'd0)));
endmodule

bind eeprom_seq eeprom_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_wide(wr_wide),
  .wr_data(wr_data), .err_clr(err_clr), .ctrl_out(ctrl_out), .busy(busy),
  .err_flag(err_flag), .err_code(err_code), .sw_go(sw_go)
);

// File: tb/eeprom_seq_tb.sv
`timescale 1ns/1ps
module eeprom_seq_tb;
  localparam int DEPTH = 512;
  localparam int AW    = 9;
  localparam int MIN   = 8;
  localparam int LAST  = DEPTH - 1;
  localparam logic [1:0] ARR = 2'd0, CTL = 2'd1, CFG = 2'd2;

  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_en = 0, wr_wide = 0, halted = 0, err_clr = 0;
  logic [1:0] wr_sel = 0;
  logic [AW-1:0] wr_addr = 0, rd_addr = 0;
  logic [7:0] wr_data = 0, rd_data;
  logic [4:0] ctrl_out;
  logic busy, err_flag;
  logic [2:0] err_code;
  int total = 0, bad = 0;
  bit ended = 0;

  always #2.5 clk = ~clk;

  eeprom_seq #(.DEPTH(DEPTH), .MIN_DWELL(MIN)) u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_wide(wr_wide),
    .wr_addr(wr_addr), .wr_data(wr_data), .halted(halted), .err_clr(err_clr),
    .rd_addr(rd_addr), .rd_data(rd_data), .ctrl_out(ctrl_out), .busy(busy),
    .err_flag(err_flag), .err_code(err_code)
  );

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] s, input int a, input logic [7:0] d, input bit wide = 0);
    wr_en = 1; wr_sel = s; wr_addr = AW'(a); wr_data = d; wr_wide = wide;
    @(negedge clk);
    wr_en = 0; wr_wide = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic peek(input int a, output int d);
    rd_addr = AW'(a); #0.5; d = int'(rd_data);
  endtask

  task automatic clr();
    err_clr = 1; @(negedge clk); err_clr = 0;
  endtask

  task automatic poke(input int a, input logic [7:0] d);
    halted = 1; wr(ARR, a, d); halted = 0;
  endtask

  int v;

  task automatic t_reset();
    chk("R14 flag after reset", err_flag, 0);
    chk("R14 code after reset", err_code, 0);
    chk("R2 ctrl after reset", ctrl_out, 0);
    chk("R11 busy after reset", busy, 0);
  endtask

  task automatic t_direct();
    poke(5, 8'hF0); poke(6, 8'h77);
    halted = 1; wr(CFG, 3, 8'h5A); halted = 0;
    peek(5, v); chk("R7 direct byte 5", v, 8'hF0);
    peek(6, v); chk("R7 direct byte 6", v, 8'h77);
    peek(LAST, v); chk("R13 config alias to top byte", v, 8'h5A);
    peek(3, v); chk("R13 alias leaves addressed byte", v == 8'h5A ? 1 : 0, 0);
    chk("R7 no error", err_flag, 0);
  endtask

  task automatic t_wide();
    halted = 1; wr(ARR, 6, 8'h00, 1); halted = 0;
    peek(6, v); chk("R1 wide leaves array", v, 8'h77);
    chk("R1 wide code", err_code, 1);
    wr(CTL, 0, 8'h01, 1);
    chk("R1 wide leaves ctrl", ctrl_out, 0);
    clr();
    wr(3, 6, 8'h00);
    peek(6, v); chk("R13 select 3 no effect", v, 8'h77);
    chk("R13 select 3 no error", err_flag, 0);
  endtask

  task automatic t_both_latch();
    wr(CTL, 0, 8'h03);
    chk("R3 ctrl unchanged", ctrl_out, 0);
    chk("R3 code", err_code, 2);
    clr();
    wr(CTL, 0, 8'h1C); chk("R4 no latch forces zero", ctrl_out, 0);
    wr(CTL, 0, 8'h0D); chk("R2 fields stored", ctrl_out, 5'h0D);
    wr(CTL, 0, 8'h0C); chk("R4 drop latch zeroes all", ctrl_out, 0);
    chk("R4 no error", err_flag, 0);
  endtask

  task automatic t_program();
    wr(ARR, 5, 8'h00);
    chk("R6 locked code", err_code, 5);
    peek(5, v); chk("R6 locked leaves array", v, 8'hF0);
    clr();
    wr(CTL, 0, 8'h01); wr(ARR, 5, 8'h3C);
    peek(5, v); chk("R6 capture leaves array", v, 8'hF0);
    chk("R6 capture no error", err_flag, 0);
    wr(ARR, 6, 8'h00);
    chk("R6 held code", err_code, 6);
    clr();
    wr(CTL, 0, 8'h03); chk("R2 vpp set", ctrl_out, 5'h03);
    idle(MIN - 1);
    wr(CTL, 0, 8'h01);
    peek(5, v); chk("R8 program AND", v, 8'h30);
    chk("R9 dwell equal to minimum ok", err_flag, 0);
    wr(ARR, 6, 8'h0F);
    chk("R8 pair released", err_flag, 0);
    wr(CTL, 0, 8'h03); idle(MIN - 2); wr(CTL, 0, 8'h01);
    chk("R9 short dwell code", err_code, 4);
    peek(6, v); chk("R9 short still programs", v, 8'h07);
    wr(CTL, 0, 8'h00); clr();
  endtask

  task automatic t_no_pair();
    wr(CTL, 0, 8'h01); wr(CTL, 0, 8'h03);
    chk("R5 no pair code", err_code, 3);
    chk("R5 write still applied", ctrl_out, 5'h03);
    clr();
    wr(CTL, 0, 8'h00);
    chk("R5 clear both legal", err_flag, 0);
    chk("R5 clear both ctrl", ctrl_out, 0);
    peek(5, v); chk("R5 no operation without pair", v, 8'h30);
  endtask

  task automatic erase_at(input logic [1:0] s, input int a, input logic [7:0] mode);
    wr(CTL, 0, mode); wr(s, a, 8'h00); wr(CTL, 0, mode | 8'h02);
    idle(MIN + 1); wr(CTL, 0, mode);
  endtask

  task automatic t_byte_erase();
    poke(7, 8'h00);
    erase_at(ARR, 5, 8'h0D);
    chk("R10 byte erase no busy", busy, 0);
    peek(5, v); chk("R10 byte erased", v, 8'hFF);
    peek(6, v); chk("R10 neighbour kept", v, 8'h07);
    peek(7, v); chk("R10 neighbour 7 kept", v, 8'h00);
    wr(CTL, 0, 8'h00);
    poke(LAST - 1, 8'h44);
    erase_at(CFG, 0, 8'h15);
    chk("R10 top byte row request no sweep", busy, 0);
    peek(LAST, v); chk("R10 top byte erased", v, 8'hFF);
    peek(LAST - 1, v); chk("R10 below top kept", v, 8'h44);
    chk("R10 no error", err_flag, 0);
    wr(CTL, 0, 8'h00);
  endtask

  task automatic count_busy(output int n);
    n = 0;
    while (busy) begin n++; @(negedge clk); end
  endtask

  task automatic t_row();
    int n;
    poke(8'h1F, 8'h00); poke(8'h20, 8'h00); poke(8'h23, 8'h00);
    poke(8'h2F, 8'h00); poke(8'h30, 8'h00);
    erase_at(ARR, 8'h23, 8'h15);
    count_busy(n); chk("R11 row cycles", n, 16);
    peek(8'h20, v); chk("R11 row base", v, 8'hFF);
    peek(8'h2F, v); chk("R11 row end", v, 8'hFF);
    peek(8'h1F, v); chk("R11 below row", v, 8'h00);
    peek(8'h30, v); chk("R11 above row", v, 8'h00);
    wr(CTL, 0, 8'h00);
    halted = 1; wr(CFG, 0, 8'h00); halted = 0;
    poke(LAST - 1, 8'h00);
    erase_at(ARR, LAST - 11, 8'h15);
    count_busy(n); chk("R11 top row cycles", n, 15);
    peek(LAST - 1, v); chk("R11 top row erased", v, 8'hFF);
    peek(LAST, v); chk("R11 top byte exempt", v, 8'h00);
    wr(CTL, 0, 8'h00);
  endtask

  task automatic t_bulk();
    int n;
    poke(0, 8'h00); poke(100, 8'h00);
    halted = 1; wr(CFG, 0, 8'h11); halted = 0;
    erase_at(ARR, 100, 8'h05);
    chk("R12 busy after launch", busy, 1);
    wr(CTL, 0, 8'h00);
    count_busy(n); chk("R12 bulk cycles", n + 1, DEPTH - 1);
    chk("R2 write during busy ignored", ctrl_out, 5'h05);
    peek(0, v); chk("R12 first byte", v, 8'hFF);
    peek(100, v); chk("R12 middle byte", v, 8'hFF);
    peek(LAST - 1, v); chk("R12 last erasable", v, 8'hFF);
    peek(LAST, v); chk("R12 top byte exempt", v, 8'h11);
    wr(CTL, 0, 8'h00);
  endtask

  task automatic t_clear_race();
    wr(CTL, 0, 8'h03);
    wr(CTL, 0, 8'h00);
    chk("R14 sticky across good write", err_flag, 1);
    err_clr = 1; wr(ARR, 0, 8'h00, 1); err_clr = 0;
    chk("R14 error beats clear flag", err_flag, 1);
    chk("R14 error beats clear code", err_code, 1);
    clr();
    chk("R14 clear flag", err_flag, 0);
    chk("R14 clear code", err_code, 0);
  endtask

  initial begin
    idle(3); rst_n = 1; idle(2);
    t_reset(); t_direct(); t_wide(); t_both_latch(); t_program();
    t_no_pair(); t_byte_erase(); t_row(); t_bulk(); t_clear_race();
    if (!ended) begin
      ended = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #(5.0 * 100000);
    if (!ended) begin
      ended = 1; total++; bad++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule